// File: doc/BRIEF.md
# Interrupt Response Controller

This block sits beside the sequencer of an 8-bit processor core and decides how the core answers an interrupt. At every instruction boundary it looks at a latched non-maskable request and a level-sensitive maskable request. It chooses which one to take, runs the acknowledge, and then produces the next program counter or an opcode for the core to execute. It also owns the interrupt-enable flag and a shadow copy of it, which is used across non-maskable service.

Maskable requests are answered in one of three selectable ways. The opcode-injection style passes the byte that the device returns on acknowledge to the core as its next instruction. The fixed-restart style jumps to a constant address. The table style forms a pointer from a page register and the device byte, and reads a 16-bit target from memory through a simple request/acknowledge handshake. The non-maskable path always wins, ignores the enable flag, and jumps to its own constant address.

Top module: `irq_resp_ctrl`

## Requirements
- R1: After reset, int_ack, inj_valid, push_pc, pc_load and mem_req are low, and ie_flag and ie_saved are 0.
- R2: Requests are sampled only on a cycle with insn_end high while the block is idle. A maskable request is taken when int_req and ie_flag are both 1. int_ack is then high for exactly the one cycle that follows the boundary, and dev_byte and vec_page are captured in that cycle.
- R3: While ie_flag is 0, or when no boundary strobe arrives, a held int_req produces no int_ack, push_pc, pc_load, inj_valid or mem_req.
- R4: In opcode mode (mode_sel = 00), inj_valid is high for one cycle right after the int_ack cycle, and inj_opcode equals the captured device byte. push_pc and pc_load stay low in this mode.
- R5: In fixed mode (mode_sel = 01), the int_ack cycle is followed by one push_pc cycle and then one pc_load cycle with pc_target = 0x0038.
- R6: In table mode (mode_sel = 10 or 11), the pointer is {vec_page, dev_byte[7:1], 0}. mem_req is held with mem_addr equal to the pointer until a cycle with mem_ack high, and mem_rdata in that cycle is the low byte. The same is then done at pointer+1 for the high byte. After that come push_pc, and then pc_load with pc_target = {high, low}.
- R7: push_pc lasts exactly one cycle and is always followed in the very next cycle by pc_load.
- R8: A rising edge on nmi_req is latched until it is taken at a boundary, whatever ie_flag holds. No int_ack is given. The cycle after the boundary is push_pc, and the cycle after that is pc_load with pc_target = 0x0066.
- R9: When a latched non-maskable request and an enabled maskable request meet at the same boundary, the non-maskable one is taken.
- R10: Taking a maskable request clears ie_flag. It stays 0 until an ie_set strobe, and ie_clr clears it.
- R11: Taking a non-maskable request copies ie_flag into ie_saved and clears ie_flag. An ie_restore strobe copies ie_saved back into ie_flag.
- R12: nmi_req held high over many cycles counts as one request only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| insn_end | input | 1 | Instruction-boundary strobe |
| int_req | input | 1 | Maskable request, level |
| nmi_req | input | 1 | Non-maskable request, rising edge |
| mode_sel | input | 2 | Maskable response mode |
| ie_set | input | 1 | Strobe that sets the enable flag |
| ie_clr | input | 1 | Strobe that clears the enable flag |
| ie_restore | input | 1 | Strobe that copies the shadow flag into the enable flag |
| vec_page | input | 8 | High byte of the vector-table pointer |
| dev_byte | input | 8 | Byte returned by the device during acknowledge |
| int_ack | output | 1 | Acknowledge strobe to the device |
| inj_valid | output | 1 | Injected opcode valid |
| inj_opcode | output | 8 | Injected opcode |
| push_pc | output | 1 | Request to push the current PC |
| pc_load | output | 1 | New PC valid |
| pc_target | output | 16 | New PC value |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 16 | Table read address |
| mem_ack | input | 1 | Table read done, data valid |
| mem_rdata | input | 8 | Table read data |
| ie_flag | output | 1 | Interrupt-enable flag |
| ie_saved | output | 1 | Shadow of the enable flag |

## Verification
Suppose the enable logic ends up in the wrong state. The ports show this at the next boundary: an int_ack appears that should not, or an expected one never comes. ie_flag and ie_saved are also outputs, so they can be checked right after each acceptance. A wrong captured device byte or a bad pointer shows up on mem_addr one cycle after the acknowledge, or on inj_opcode in that same cycle. A wrong assembled target shows up on pc_target when pc_load rises, two cycles after the high-byte handshake. A lost or repeated non-maskable latch shows as a missing or extra push_pc at the next boundary.

// File: rtl/irq_resp_pkg.sv
package irq_resp_pkg;
  parameter int unsigned IRQ_DW = 8;
  parameter int unsigned IRQ_AW = 2 * IRQ_DW;

  typedef enum logic [1:0] {
    IM_OPCODE = 2'd0,
    IM_FIXED  = 2'd1,
    IM_TABLE  = 2'd2
  } irq_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACK,
    S_INJ,
    S_VWAIT,
    S_PUSH,
    S_LOAD
  } irq_state_e;

  // Mode-select decode: the upper bit picks the table style.
  function automatic irq_mode_e decode_mode(input logic [1:0] sel);
    if (sel[1])      return IM_TABLE;
    else if (sel[0]) return IM_FIXED;
    else             return IM_OPCODE;
  endfunction

  // Table pointer: page in the high byte, even entry chosen by the device byte.
  function automatic logic [IRQ_AW-1:0] table_ptr(input logic [IRQ_DW-1:0] page,
                                                  input logic [IRQ_DW-1:0] dbyte);
    return {page, dbyte[IRQ_DW-1:1], 1'b0};
  endfunction

  // Second table byte: the pointer is even, so the step never carries.
  function automatic logic [IRQ_AW-1:0] table_ptr_hi(input logic [IRQ_AW-1:0] ptr);
    return ptr | IRQ_AW'(1);
  endfunction
endpackage

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic nmi_take,
  output logic nmi_pend
);
  logic nmi_prev;
  logic nmi_rise;

  assign nmi_rise = nmi_req && !nmi_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_prev <= nmi_req;
      if (nmi_rise)      nmi_pend <= 1'b1;
      else if (nmi_take) nmi_pend <= 1'b0;
    end
  end

  // R8: a latched request survives until it is taken
  p_nmi_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend && !nmi_take |=> nmi_pend);

  // R12: a held level does not re-arm after service
  p_nmi_level_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take && nmi_req && $past(nmi_req) |=> !nmi_pend);
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic mask_take,
  input  logic nmi_take,
  input  logic ie_set,
  input  logic ie_clr,
  input  logic ie_restore,
  output logic ie_flag,
  output logic ie_saved
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_flag  <= 1'b0;
      ie_saved <= 1'b0;
    end else if (nmi_take) begin
      ie_saved <= ie_flag;
      ie_flag  <= 1'b0;
    end else if (mask_take) begin
      ie_flag  <= 1'b0;
    end else if (ie_restore) begin
      ie_flag  <= ie_saved;
    end else if (ie_set) begin
      ie_flag  <= 1'b1;
    end else if (ie_clr) begin
      ie_flag  <= 1'b0;
    end
  end

  // R10: acceptance of a maskable request leaves the flag clear
  p_mask_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_take |=> !ie_flag);

  // R10: the flag only rises on an explicit set or restore
  p_flag_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ie_flag) |-> $past(ie_set) || $past(ie_restore));

  // R11: the non-maskable path saves and clears
  p_nmi_save_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |=> !ie_flag && (ie_saved == $past(ie_flag)));
endmodule

// File: rtl/irq_vec_fetch.sv
module irq_vec_fetch
  import irq_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IRQ_DW-1:0] page,
  input  logic [IRQ_DW-1:0] dbyte,
  output logic              mem_req,
  output logic [IRQ_AW-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [IRQ_DW-1:0] mem_rdata,
  output logic              done,
  output logic [IRQ_AW-1:0] vec
);
  typedef enum logic [1:0] {F_IDLE, F_LO, F_HI} fetch_state_e;

  fetch_state_e      st;
  logic [IRQ_AW-1:0] ptr_q;
  logic [IRQ_DW-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= F_IDLE;
      ptr_q <= '0;
      lo_q  <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          ptr_q <= table_ptr(page, dbyte);
          st    <= F_LO;
        end
        F_LO: if (mem_ack) begin
          lo_q <= mem_rdata;
          st   <= F_HI;
        end
        F_HI: if (mem_ack) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  assign mem_req  = (st != F_IDLE);
  assign mem_addr = (st == F_HI) ? table_ptr_hi(ptr_q) : ptr_q;
  assign done     = (st == F_HI) && mem_ack;
  assign vec      = {mem_rdata, lo_q};

  // R6: request and address hold until the memory answers
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R6: the second read follows the first at the odd neighbour address
  p_hi_follows_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_addr[0] |=> mem_req && mem_addr[0]
      && (mem_addr[IRQ_AW-1:1] == $past(mem_addr[IRQ_AW-1:1])));
endmodule

// File: rtl/irq_resp_ctrl.sv
module irq_resp_ctrl
  import irq_resp_pkg::*;
#(
  parameter logic [IRQ_AW-1:0] FIXED_VEC = 16'h0038,
  parameter logic [IRQ_AW-1:0] NMI_VEC   = 16'h0066
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end,
  input  logic              int_req,
  input  logic              nmi_req,
  input  logic [1:0]        mode_sel,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              ie_restore,
  input  logic [IRQ_DW-1:0] vec_page,
  input  logic [IRQ_DW-1:0] dev_byte,
  output logic              int_ack,
  output logic              inj_valid,
  output logic [IRQ_DW-1:0] inj_opcode,
  output logic              push_pc,
  output logic              pc_load,
  output logic [IRQ_AW-1:0] pc_target,
  output logic              mem_req,
  output logic [IRQ_AW-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [IRQ_DW-1:0] mem_rdata,
  output logic              ie_flag,
  output logic              ie_saved
);
  irq_state_e        state;
  irq_mode_e         mode_q;
  logic              is_nmi_q;
  logic [IRQ_AW-1:0] target_q;
  logic [IRQ_DW-1:0] opcode_q;

  // Named internal events
  logic              at_boundary;
  logic              nmi_pend;
  logic              nmi_take;
  logic              mask_take;
  logic              fetch_start;
  logic              fetch_done;
  logic [IRQ_AW-1:0] fetch_vec;

  assign at_boundary = insn_end && (state == S_IDLE);
  assign nmi_take    = at_boundary && nmi_pend;
  assign mask_take   = at_boundary && !nmi_pend && int_req && ie_flag;
  assign fetch_start = (state == S_ACK) && (mode_q == IM_TABLE);

  irq_nmi_edge u_nmi (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_req  (nmi_req),
    .nmi_take (nmi_take),
    .nmi_pend (nmi_pend)
  );

  irq_enable_ctl u_ie (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_take  (mask_take),
    .nmi_take   (nmi_take),
    .ie_set     (ie_set),
    .ie_clr     (ie_clr),
    .ie_restore (ie_restore),
    .ie_flag    (ie_flag),
    .ie_saved   (ie_saved)
  );

  irq_vec_fetch u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fetch_start),
    .page      (vec_page),
    .dbyte     (dev_byte),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .done      (fetch_done),
    .vec       (fetch_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_q   <= IM_OPCODE;
      is_nmi_q <= 1'b0;
      target_q <= '0;
      opcode_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (nmi_take) begin
            is_nmi_q <= 1'b1;
            target_q <= NMI_VEC;
            state    <= S_PUSH;
          end else if (mask_take) begin
            is_nmi_q <= 1'b0;
            mode_q   <= decode_mode(mode_sel);
            state    <= S_ACK;
          end
        end
        S_ACK: begin
          opcode_q <= dev_byte;
          case (mode_q)
            IM_OPCODE: state <= S_INJ;
            IM_FIXED: begin
              target_q <= FIXED_VEC;
              state    <= S_PUSH;
            end
            default:   state <= S_VWAIT;
          endcase
        end
        S_INJ:   state <= S_IDLE;
        S_VWAIT: if (fetch_done) begin
          target_q <= fetch_vec;
          state    <= S_PUSH;
        end
        S_PUSH:  state <= S_LOAD;
        S_LOAD:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign int_ack    = (state == S_ACK);
  assign inj_valid  = (state == S_INJ);
  assign inj_opcode = opcode_q;
  assign push_pc    = (state == S_PUSH);
  assign pc_load    = (state == S_LOAD);
  assign pc_target  = target_q;

  // R2: an acknowledge only follows an enabled boundary
  p_ack_from_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_ack) |-> $past(insn_end) && $past(ie_flag) && $past(int_req));

  // R3: no enable, no acknowledge
  p_no_ack_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_flag && !nmi_pend |=> !int_ack);

  // R4: the injected opcode comes right after the acknowledge
  p_inj_after_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    inj_valid |-> $past(int_ack) && !push_pc && !pc_load);

  // R5: the fixed mode target
  p_fixed_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load && !is_nmi_q && (mode_q == IM_FIXED) |-> pc_target == FIXED_VEC);

  // R7: push precedes the load by one cycle
  p_push_then_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_pc |=> pc_load && !push_pc);

  p_load_after_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $past(push_pc));

  // R8: the non-maskable target
  p_nmi_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load && is_nmi_q |-> pc_target == NMI_VEC);

  // R9: a pending non-maskable request blocks the acknowledge
  p_nmi_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    at_boundary && nmi_pend |=> !int_ack && push_pc);
endmodule

// File: tb/irq_resp_ctrl_tb.sv
module irq_resp_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_end = 1'b0;
  logic        int_req = 1'b0;
  logic        nmi_req = 1'b0;
  logic [1:0]  mode_sel = 2'd0;
  logic        ie_set = 1'b0;
  logic        ie_clr = 1'b0;
  logic        ie_restore = 1'b0;
  logic [7:0]  vec_page = 8'd0;
  logic [7:0]  dev_byte = 8'd0;
  logic        int_ack;
  logic        inj_valid;
  logic [7:0]  inj_opcode;
  logic        push_pc;
  logic        pc_load;
  logic [15:0] pc_target;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'd0;
  logic        ie_flag;
  logic        ie_saved;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irq_resp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .insn_end(insn_end), .int_req(int_req),
    .nmi_req(nmi_req), .mode_sel(mode_sel), .ie_set(ie_set), .ie_clr(ie_clr),
    .ie_restore(ie_restore), .vec_page(vec_page), .dev_byte(dev_byte),
    .int_ack(int_ack), .inj_valid(inj_valid), .inj_opcode(inj_opcode),
    .push_pc(push_pc), .pc_load(pc_load), .pc_target(pc_target),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .ie_flag(ie_flag), .ie_saved(ie_saved)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [7:0] mem_model(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5C;
  endfunction

  task automatic quiet(input string tag);
    chk({tag, " int_ack"}, 16'(int_ack), 16'd0);
    chk({tag, " push_pc"}, 16'(push_pc), 16'd0);
    chk({tag, " pc_load"}, 16'(pc_load), 16'd0);
    chk({tag, " inj_valid"}, 16'(inj_valid), 16'd0);
    chk({tag, " mem_req"}, 16'(mem_req), 16'd0);
  endtask

  task automatic pulse_ie_set();
    ie_set = 1'b1; tick(); ie_set = 1'b0;
  endtask

  task automatic boundary();
    insn_end = 1'b1; tick(); insn_end = 1'b0;
  endtask

  task automatic serve(input logic [15:0] addr, input int waits);
    for (int w = 0; w < waits; w++) begin
      chk("R6 req held", 16'(mem_req), 16'd1);
      chk("R6 addr held", mem_addr, addr);
      tick();
    end
    chk("R6 req", 16'(mem_req), 16'd1);
    chk("R6 addr", mem_addr, addr);
    mem_ack = 1'b1;
    mem_rdata = mem_model(addr);
    tick();
    mem_ack = 1'b0;
  endtask

  task automatic do_mask(input logic [1:0] m, input logic [7:0] b,
                         input logic [7:0] p, input int waits);
    logic [15:0] ptr;
    mode_sel = m; dev_byte = b; vec_page = p; int_req = 1'b1;
    pulse_ie_set();
    chk("R10 set", 16'(ie_flag), 16'd1);
    boundary();
    chk("R2 ack", 16'(int_ack), 16'd1);
    chk("R2 no push during ack", 16'(push_pc), 16'd0);
    int_req = 1'b0;
    tick();
    dev_byte = ~b;
    vec_page = ~p;
    chk("R10 cleared", 16'(ie_flag), 16'd0);
    chk("R2 ack single", 16'(int_ack), 16'd0);
    if (m == 2'd0) begin
      chk("R4 inj_valid", 16'(inj_valid), 16'd1);
      chk("R4 opcode", 16'(inj_opcode), 16'(b));
      chk("R4 no push", 16'(push_pc), 16'd0);
      tick();
      quiet("R4 after");
    end else if (m == 2'd1) begin
      chk("R5 push", 16'(push_pc), 16'd1);
      tick();
      chk("R7 load", 16'(pc_load), 16'd1);
      chk("R5 target", pc_target, 16'h0038);
      chk("R7 push single", 16'(push_pc), 16'd0);
      tick();
      quiet("R5 after");
    end else begin
      ptr = {p, b[7:1], 1'b0};
      serve(ptr, waits);
      serve(ptr | 16'd1, waits);
      chk("R6 req drop", 16'(mem_req), 16'd0);
      chk("R7 push", 16'(push_pc), 16'd1);
      tick();
      chk("R7 load", 16'(pc_load), 16'd1);
      chk("R6 target", pc_target, {mem_model(ptr | 16'd1), mem_model(ptr)});
      tick();
      quiet("R6 after");
    end
  endtask

  task automatic finish_run();
    if (fails == 0) $display("PASS");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1
    quiet("R1 reset");
    chk("R1 ie_flag", 16'(ie_flag), 16'd0);
    chk("R1 ie_saved", 16'(ie_saved), 16'd0);

    // R3: request held with the flag clear, boundaries given
    int_req = 1'b1;
    mode_sel = 2'd1;
    for (int k = 0; k < 4; k++) begin
      boundary();
      quiet("R3 disabled");
      tick();
      quiet("R3 disabled later");
    end
    // R2/R3: flag set but no boundary strobe
    pulse_ie_set();
    for (int k = 0; k < 6; k++) begin
      tick();
      quiet("R3 no boundary");
    end
    // R10: ie_clr turns the flag off, and the request is then ignored
    ie_clr = 1'b1; tick(); ie_clr = 1'b0;
    chk("R10 clr", 16'(ie_flag), 16'd0);
    boundary();
    quiet("R3 after clr");
    int_req = 1'b0;

    // R4: every device byte in opcode mode
    for (int i = 0; i < 256; i++) do_mask(2'd0, 8'(i), 8'h00, 0);
    // R5: fixed mode, different bytes do not matter
    for (int i = 0; i < 8; i++) do_mask(2'd1, 8'(i * 37), 8'(i), 0);
    // R6: every device byte in table mode, both encodings, varied waits
    for (int i = 0; i < 256; i++)
      do_mask((i % 2 == 0) ? 2'd2 : 2'd3, 8'(i), 8'(i * 53 + 7), i % 3);

    // R10: after acceptance, a held request is not taken again
    mode_sel = 2'd1;
    int_req = 1'b1;
    pulse_ie_set();
    boundary();
    chk("R10 first ack", 16'(int_ack), 16'd1);
    repeat (3) tick();
    boundary();
    quiet("R10 held request ignored");
    int_req = 1'b0;

    // R8/R9/R11: non-maskable request meets an enabled maskable one
    pulse_ie_set();
    int_req = 1'b1;
    nmi_req = 1'b1; tick(); nmi_req = 1'b0;
    tick();
    quiet("R8 latched, waiting for boundary");
    boundary();
    chk("R9 no ack", 16'(int_ack), 16'd0);
    chk("R8 push", 16'(push_pc), 16'd1);
    chk("R11 ie cleared", 16'(ie_flag), 16'd0);
    chk("R11 ie saved", 16'(ie_saved), 16'd1);
    tick();
    chk("R8 load", 16'(pc_load), 16'd1);
    chk("R8 target", pc_target, 16'h0066);
    tick();
    boundary();
    quiet("R11 masked during service");
    ie_restore = 1'b1; tick(); ie_restore = 1'b0;
    chk("R11 restored", 16'(ie_flag), 16'd1);
    boundary();
    chk("R11 maskable after restore", 16'(int_ack), 16'd1);
    int_req = 1'b0;
    tick();
    chk("R5 push after restore", 16'(push_pc), 16'd1);
    tick();
    chk("R5 target after restore", pc_target, 16'h0038);
    tick();

    // R8/R11: taken with the flag clear, shadow holds 0
    chk("R8 flag clear before", 16'(ie_flag), 16'd0);
    nmi_req = 1'b1; tick(); nmi_req = 1'b0;
    boundary();
    chk("R8 push with flag clear", 16'(push_pc), 16'd1);
    chk("R11 saved zero", 16'(ie_saved), 16'd0);
    tick();
    chk("R8 target again", pc_target, 16'h0066);
    tick();

    // R12: a held level counts once
    nmi_req = 1'b1;
    repeat (5) tick();
    boundary();
    chk("R12 first take", 16'(push_pc), 16'd1);
    repeat (4) tick();
    boundary();
    quiet("R12 no second take");
    tick();
    quiet("R12 no second take later");
    nmi_req = 1'b0;
    tick();

    finish_run();
  end
endmodule